// File: doc/BRIEF.md
# Sync Edge Sense Status Register

An 8-bit status register that watches five external video sync and feedback pins: vertical sync, horizontal sync, composite sync, horizontal feedback and vertical feedback. Each pin passes through a synchronizer. A rising edge on a pin sets a sticky flag. A sixth sticky flag records a pre-equalization event. That event arrives from an external detector as a one-cycle pulse in the register's clock domain. The two lowest bits are not stored. They show the live levels of the internal horizontal and vertical sync signals.

Software reads the register through a simple strobe bus. It clears a flag by writing 0 to it, but only after a read has returned that flag as 1. Every flag has its own arm bit. A read that returns the flag as 1 sets the arm bit, and any write drops it. A flag that is not armed keeps its value when 0 is written to it. Writing 1 to a flag never changes the flag.

Top module: `sync_edge_status`

## Requirements
- R1: `rd_data` bit 7 is the vertical-sync edge flag, bit 6 horizontal-sync, bit 5 composite-sync, bit 4 horizontal-feedback, bit 3 vertical-feedback, bit 2 pre-equalization, bit 1 the internal horizontal sync level, bit 0 the internal vertical sync level.
- R2: A 0-to-1 change on a pin sets its flag. The flag becomes visible on `rd_data` exactly SYNC_STAGES+1 rising clock edges after the new pin level is applied. A pin held high does not set the flag again.
- R3: A one-cycle high on `preeq_pulse` sets bit 2 at the next rising edge.
- R4: While reset is asserted, and directly after it, flags 7..2 read 0 and every arm bit is clear.
- R5: Bits 1 and 0 follow `ihsync_lvl` and `ivsync_lvl` combinationally. Writes never affect them.
- R6: Writing 1 to a flag leaves that flag unchanged and disarms it. A later write of 0 with no read in between leaves the flag set.
- R7: Writing 0 to a flag that is not armed leaves the flag unchanged.
- R8: A read with `rd_en` high that returns a flag as 1, with no write in the same cycle, arms that flag. The next write of 0 to that flag clears it.
- R9: If a new event for a flag occurs in the same cycle as a clearing write, the flag stays 1 and its arm bit clears.
- R10: A pin level present at reset release is not reported as an edge. Edge detection starts SYNC_STAGES+2 clock edges after the release.
- R11: When `rd_en` and `wr_en` are high in the same cycle, the write acts on the arm state from before that cycle, and the read arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe; arms flags read as 1 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; a 0 in bits 7..2 requests a clear |
| rd_data | output | 8 | Register contents |
| vsync_pin | input | 1 | Vertical sync pin (asynchronous) |
| hsync_pin | input | 1 | Horizontal sync pin (asynchronous) |
| csync_pin | input | 1 | Composite sync pin (asynchronous) |
| hfb_pin | input | 1 | Horizontal feedback pin (asynchronous) |
| vfb_pin | input | 1 | Vertical feedback pin (asynchronous) |
| preeq_pulse | input | 1 | One-cycle pre-equalization event |
| ihsync_lvl | input | 1 | Internal horizontal sync level |
| ivsync_lvl | input | 1 | Internal vertical sync level |

## Verification
The bench builds the block with its default SYNC_STAGES of 2. It computes the pin-to-flag latency of R2 and the startup window of R10 from that same parameter, so a different synchronizer depth is checked without any change to the bench. With a short chain, a pin toggling about every four cycles produces many rising edges that land in the same cycle as reads, writes and pulses. This makes the coincidence cases of R9 and R11 occur often in the random phase, in addition to the directed sequences.

// File: rtl/sync_edge_status.sv
module sync_edge_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       vsync_pin,
  input  logic       hsync_pin,
  input  logic       csync_pin,
  input  logic       hfb_pin,
  input  logic       vfb_pin,
  input  logic       preeq_pulse,
  input  logic       ihsync_lvl,
  input  logic       ivsync_lvl
);

  localparam int NPIN  = 5;
  localparam int NFLAG = NPIN + 1;
  localparam int PRIME = SYNC_STAGES + 1;

  logic [NPIN-1:0]  pins_raw;
  logic [NPIN-1:0]  sync_q [SYNC_STAGES];
  logic [NPIN-1:0]  prev_q;
  logic [PRIME-1:0] prime_q;
  logic             primed;
  logic [NPIN-1:0]  pin_rise;
  logic [NFLAG-1:0] evt, clr, flag_q, flag_d, arm_q, arm_d;

  assign pins_raw = {vsync_pin, hsync_pin, csync_pin, hfb_pin, vfb_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      sync_q[0] <= pins_raw;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q  <= sync_q[SYNC_STAGES-1];
      prime_q <= {prime_q[PRIME-2:0], 1'b1};
    end
  end

  assign primed   = prime_q[PRIME-1];
  assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q & {NPIN{primed}};
  assign evt      = {pin_rise, preeq_pulse};
  assign clr      = {NFLAG{wr_en}} & ~wr_data[7:2] & arm_q;
  assign flag_d   = evt | (flag_q & ~clr);
  assign arm_d    = wr_en ? '0 : (arm_q | ({NFLAG{rd_en}} & flag_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign rd_data = {flag_q, ihsync_lvl, ivsync_lvl};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_chk
      p_clear_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[i]) |-> $past(wr_en && !wr_data[i+2] && arm_q[i]));
      p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flag_q[i]);
      p_arm_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_q[i]) |-> $past(rd_en && !wr_en && flag_q[i]));
      p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(evt[i]));
    end
  endgenerate

  p_write_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (arm_q == '0));
  p_quiet_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> (flag_q[NFLAG-1:1] == '0) || $past(flag_q[NFLAG-1:1] != '0));

endmodule

// File: tb/test_sync_edge_status.sv
module test_sync_edge_status;
  localparam int S = 2;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, preeq = 0, lh = 0, lv = 0;
  logic [7:0] wd = 0;
  logic [4:0] pins = 0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, m = 0;
  logic [5:0] mflag = 0, marm = 0;
  logic [4:0] ph [$];

  always #10 clk = ~clk;

  sync_edge_status #(.SYNC_STAGES(S)) i_sync_edge_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wd),
    .rd_data(rd_data), .vsync_pin(pins[4]), .hsync_pin(pins[3]),
    .csync_pin(pins[2]), .hfb_pin(pins[1]), .vfb_pin(pins[0]),
    .preeq_pulse(preeq), .ihsync_lvl(lh), .ivsync_lvl(lv));

  function automatic logic [5:0] next_flag(logic [5:0] f, logic [5:0] a, logic [5:0] e,
                                           logic w, logic [7:0] d);
    return e | (f & ~({6{w}} & ~d[7:2] & a));
  endfunction

  function automatic logic [5:0] next_arm(logic [5:0] f, logic [5:0] a, logic r, logic w);
    return w ? 6'b0 : (a | ({6{r}} & f));
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s rd_data=%h expected %h", tag, rd_data, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [7:0] d, input logic [4:0] p,
                      input logic pq, input logic [1:0] lvl, input string tag);
    logic [5:0] e;
    @(negedge clk);
    rd_en = r; wr_en = w; wd = d; pins = p; preeq = pq; {lh, lv} = lvl;
    #1;
    check({mflag, lvl}, tag);
    m++;
    ph.push_front(p);
    e = {5'b0, pq};
    if (m >= S + 2) e[5:1] = ph[S] & ~ph[S+1];
    @(posedge clk);
    {mflag, marm} = {next_flag(mflag, marm, e, w, d), next_arm(mflag, marm, r, w)};
  endtask

  task automatic do_reset(input logic [4:0] p);
    @(negedge clk);
    rst_n = 0; pins = p; rd_en = 0; wr_en = 0; preeq = 0;
    mflag = 0; marm = 0; m = 0; ph.delete();
    repeat (3) @(negedge clk);
    #1 check({6'b0, lh, lv}, "R4 during reset");
    rst_n = 1;
  endtask

  task automatic idle(input int n, input logic [4:0] p, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 8'hFF, p, 0, 2'b00, tag);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] p;
    void'($urandom(32'h5EED));
    do_reset(5'b0);
    idle(3, 5'b0, "R4 after reset");
    // R2 rising vsync, latency S+1
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R2");
    for (int k = 0; k < S; k++) step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R2 latency");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b10, "R2 R1 bit7 set");
    idle(4, 5'b10000, "R2 held high no retrigger");
    // R7 write 0 unarmed
    step(0, 1, 8'h00, 5'b10000, 0, 2'b01, "R7 unarmed write");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R7 flag kept");
    // R6 read, write 1, then write 0
    step(1, 0, 8'hFF, 5'b10000, 0, 2'b00, "R8 read arms");
    step(0, 1, 8'hFF, 5'b10000, 0, 2'b00, "R6 write one");
    step(0, 1, 8'h00, 5'b10000, 0, 2'b00, "R6 disarmed");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R6 flag kept");
    // R8 read then clear
    step(1, 0, 8'hFF, 5'b10000, 0, 2'b00, "R8 read");
    step(0, 1, 8'h7F, 5'b10000, 0, 2'b00, "R8 clear");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b11, "R8 cleared R5 levels");
    // R3 pre-equalization
    step(0, 0, 8'hFF, 5'b10000, 1, 2'b00, "R3 pulse");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R3 bit2 set");
    // R9 event with clear
    step(1, 0, 8'hFF, 5'b10000, 0, 2'b00, "R9 read");
    step(0, 1, 8'h00, 5'b10000, 1, 2'b00, "R9 clear with event");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R9 flag kept");
    step(0, 1, 8'h00, 5'b10000, 0, 2'b00, "R9 arm cleared");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R9 still set");
    // R11 read and write together
    step(1, 1, 8'h00, 5'b10000, 0, 2'b00, "R11 same cycle");
    step(0, 1, 8'h00, 5'b10000, 0, 2'b00, "R11 no arm");
    step(0, 0, 8'hFF, 5'b10000, 0, 2'b00, "R11 still set");
    // R10 pins high through reset
    do_reset(5'b11111);
    idle(S + 6, 5'b11111, "R10 no edge at start");
    // random phase
    p = 0;
    for (int k = 0; k < 3000; k++) begin
      p = p ^ (5'($urandom) & 5'($urandom));
      step($urandom_range(1), $urandom_range(3) == 0, 8'($urandom), p,
           $urandom_range(7) == 0, 2'($urandom), "random R1 R2 R3 R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule